// File: doc/BRIEF.md
# Descriptor Ring Position Tracker

This block keeps track of where a DMA engine stands in a circular ring of descriptors. It holds a ring-length register and a position counter, both stored as negative two's complement numbers. It also holds two shadow registers that copy the byte count and the status word of the descriptor that comes next. From these it produces the zero-based index of the current descriptor and that descriptor's address in memory.

The counter starts at the ring-length value. Each step from the DMA engine moves it one slot towards zero. Zero marks the last slot, and a step taken at zero returns the counter to the ring-length value.

The registers are set in one of two ways. An initialization load writes the ring length and the counter together. After that, the host can read and write the registers, but only while the engine is stopped or suspended. Outside those windows, host access has no effect. Reset clears only the read-data register and leaves all ring state as it was.

Top module: `ring_pos_tracker`

## Requirements
- R1: The host selects a register with `hostSel`: 0 selects ring length, 1 the counter, 2 the next-byte-count shadow, 3 the next-status shadow. While `stopCtl` or `suspendCtl` is high, a host write updates the selected register on the next clock edge. A host read presents its value on `hostRdata` one cycle after the read strobe.
- R2: While both `stopCtl` and `suspendCtl` are low, host writes are dropped and change no register, and a host read returns zero on `hostRdata` one cycle later. `hostRdata` is also zero one cycle after any cycle with no read.
- R3: Bits 31:16 of a write are ignored for every register, and `hostRdata[31:16]` always reads zero.
- R4: A pulse on `initLoad` loads both the ring length and the counter from `initLen`, so the index becomes 0. This load takes priority over a host write and over an advance in the same cycle.
- R5: An `advance` pulse while the counter is not zero adds one to the counter (modulo 2^16).
- R6: An `advance` pulse while the counter is zero reloads the counter with the ring-length value, so the index returns to 0.
- R7: `descIndex` always equals the counter minus the ring length, modulo 2^16. It follows the registers combinationally.
- R8: `descAddr` always equals `ringBase` plus 16 times `descIndex`, modulo 2^32.
- R9: When a permitted host write to the counter and an `advance` pulse arrive in the same cycle, the counter takes the host value.
- R10: Asserting `rstN` low clears `hostRdata` but leaves the ring length, counter and both shadow registers unchanged.
- R11: The next-byte-count shadow keeps only bits 11:0 of a write, so bits 31:12 read zero. The next-status shadow keeps bits 15:0. Both follow the access rule of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the read-data register |
| stopCtl | input | 1 | Engine stopped; permits host access |
| suspendCtl | input | 1 | Engine suspended; permits host access |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostSel | input | 2 | Register select |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, one cycle after the read strobe |
| initLoad | input | 1 | Initialization load of ring length and counter |
| initLen | input | 16 | Two's complement ring length for initialization |
| advance | input | 1 | Step pulse from the DMA engine |
| ringBase | input | 32 | Byte address of descriptor 0 |
| descIndex | output | 16 | Current descriptor index |
| descAddr | output | 32 | Current descriptor address |

## Verification
Register updates from writes, `initLoad` and `advance` show on `descIndex` and `descAddr` right after the clock edge that samples them. Read data shows on `hostRdata` after that same edge. The bench drives its inputs on the falling edge and samples every output on the following falling edge. It advances a behavioural model of the registers at each rising edge and compares all three outputs once per cycle. Directed checks then place host writes, advances and loads in the same cycle to confirm which one wins.

// File: rtl/ring_pos_pkg.sv
package ring_pos_pkg;
  typedef enum logic [1:0] {SEL_LEN = 2'd0, SEL_CNT = 2'd1, SEL_NBC = 2'd2, SEL_NST = 2'd3} regSel_e;

  typedef struct packed {
    logic ldInit;
    logic wrLen;
    logic wrCnt;
    logic wrNbc;
    logic wrNst;
    logic step;
    logic rdEn;
  } ringStrobes_t;
endpackage

// File: rtl/ring_pos_ctrl.sv
module ring_pos_ctrl
  import ring_pos_pkg::*;
(
  input  logic         stopCtl,
  input  logic         suspendCtl,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [1:0]   hostSel,
  input  logic         initLoad,
  input  logic         advance,
  output ringStrobes_t strb
);
  logic       accessOk;
  logic [3:0] wrVec;

  assign accessOk = stopCtl | suspendCtl;

  // one-hot write decode, only when the engine is idle
  always_comb begin
    wrVec = '0;
    if (hostWr && accessOk) wrVec[hostSel] = 1'b1;
  end

  always_comb begin
    strb        = '0;
    strb.ldInit = initLoad;
    strb.wrLen  = wrVec[SEL_LEN];
    strb.wrCnt  = wrVec[SEL_CNT];
    strb.wrNbc  = wrVec[SEL_NBC];
    strb.wrNst  = wrVec[SEL_NST];
    strb.step   = advance;
    strb.rdEn   = hostRd & accessOk;
  end
endmodule

// File: rtl/ring_pos_dp.sv
module ring_pos_dp
  import ring_pos_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NBC_W      = 12,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobes_t      strb,
  input  logic [1:0]        hostSel,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  initLen,
  input  logic [ADDR_W-1:0] ringBase,
  output logic [DATA_W-1:0] hostRdata,
  output logic [CNT_W-1:0]  descIndex,
  output logic [ADDR_W-1:0] descAddr,
  output logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  lenQ
);
  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_NBC = DATA_W - NBC_W;

  logic [NBC_W-1:0]  nbcQ;
  logic [CNT_W-1:0]  nstQ;
  logic [DATA_W-1:0] rdMux;

  // ring state carries no reset: it survives every reset
  always_ff @(posedge clk) begin
    if (strb.ldInit)     lenQ <= initLen;
    else if (strb.wrLen) lenQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strb.ldInit)     cntQ <= initLen;
    else if (strb.wrCnt) cntQ <= wrData;
    else if (strb.step)  cntQ <= (cntQ == '0) ? lenQ : cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.wrNbc) nbcQ <= wrData[NBC_W-1:0];
    if (strb.wrNst) nstQ <= wrData;
  end

  always_comb begin
    unique case (regSel_e'(hostSel))
      SEL_LEN: rdMux = {{PAD_CNT{1'b0}}, lenQ};
      SEL_CNT: rdMux = {{PAD_CNT{1'b0}}, cntQ};
      SEL_NBC: rdMux = {{PAD_NBC{1'b0}}, nbcQ};
      default: rdMux = {{PAD_CNT{1'b0}}, nstQ};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          hostRdata <= '0;
    else if (strb.rdEn) hostRdata <= rdMux;
    else                hostRdata <= '0;
  end

  assign descIndex = cntQ - lenQ;
  assign descAddr  = ringBase + (ADDR_W'(descIndex) << DESC_SHIFT);
endmodule

// File: rtl/ring_pos_tracker.sv
module ring_pos_tracker
  import ring_pos_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NBC_W      = 12,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopCtl,
  input  logic              suspendCtl,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              initLoad,
  input  logic [CNT_W-1:0]  initLen,
  input  logic              advance,
  input  logic [ADDR_W-1:0] ringBase,
  output logic [CNT_W-1:0]  descIndex,
  output logic [ADDR_W-1:0] descAddr
);
  ringStrobes_t     strb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] lenVal;

  ring_pos_ctrl uCtrl (
    .stopCtl(stopCtl), .suspendCtl(suspendCtl), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .initLoad(initLoad), .advance(advance), .strb(strb)
  );

  ring_pos_dp #(
    .CNT_W(CNT_W), .NBC_W(NBC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DESC_SHIFT(DESC_SHIFT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSel(hostSel), .wrData(hostWdata[CNT_W-1:0]),
    .initLen(initLen), .ringBase(ringBase), .hostRdata(hostRdata), .descIndex(descIndex),
    .descAddr(descAddr), .cntQ(cntVal), .lenQ(lenVal)
  );
endmodule

// File: rtl/ring_pos_chk.sv
module ring_pos_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopCtl,
  input logic              suspendCtl,
  input logic              hostWr,
  input logic              hostRd,
  input logic [1:0]        hostSel,
  input logic [DATA_W-1:0] hostWdata,
  input logic [DATA_W-1:0] hostRdata,
  input logic              initLoad,
  input logic              advance,
  input logic [CNT_W-1:0]  descIndex,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  lenVal
);
  logic accessOk;
  logic cntTouch;
  assign accessOk = stopCtl | suspendCtl;
  assign cntTouch = initLoad | (hostWr & accessOk & (hostSel == 2'd1));

  // R2
  gated_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !accessOk) |=> (hostRdata == '0));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdata[DATA_W-1:CNT_W] == '0);

  // R4
  init_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    initLoad |=> (cntVal == lenVal) && (descIndex == '0));

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !cntTouch && cntVal != '0) |=> (cntVal == $past(cntVal) + 1'b1));

  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !cntTouch && cntVal == '0) |=> (descIndex == '0));

  // R7
  last_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0) |-> (descIndex == CNT_W'(0) - lenVal));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !initLoad && hostWr && accessOk && hostSel == 2'd1)
      |=> (cntVal == $past(hostWdata[CNT_W-1:0])));
endmodule

bind ring_pos_tracker ring_pos_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .stopCtl(stopCtl), .suspendCtl(suspendCtl), .hostWr(hostWr),
  .hostRd(hostRd), .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
  .initLoad(initLoad), .advance(advance), .descIndex(descIndex), .cntVal(cntVal), .lenVal(lenVal)
);

// File: tb/sim_ring_pos_tracker.sv
`timescale 1ns/1ps
module sim_ring_pos_tracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stopCtl = 1'b1, suspendCtl = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        initLoad = 1'b0;
  logic [15:0] initLen = '0;
  logic        advance = 1'b0;
  logic [31:0] ringBase = 32'h1000_0000;
  logic [15:0] descIndex;
  logic [31:0] descAddr;

  int tests = 0, fails = 0;
  bit modelOn = 0, done = 0;
  int mLen = 0, mCnt = 0, mNbc = 0, mNst = 0;
  longint mRd = 0;

  always #4 clk = ~clk;

  ring_pos_tracker u0 (.*);

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped at each rising edge
  always @(posedge clk) begin
    int nLen, nCnt, v;
    bit ok;
    ok = stopCtl || suspendCtl;
    v = int'(hostWdata & 32'hFFFF);
    nLen = mLen; nCnt = mCnt;
    if (advance) nCnt = (mCnt == 0) ? mLen : (mCnt + 1) % 65536;
    if (hostWr && ok && hostSel == 0) nLen = v;
    if (hostWr && ok && hostSel == 1) nCnt = v;
    if (hostWr && ok && hostSel == 2) mNbc = v % 4096;
    if (hostWr && ok && hostSel == 3) mNst = v;
    if (initLoad) begin nLen = int'(initLen); nCnt = int'(initLen); end
    if (!rstN || !(hostRd && ok)) mRd = 0;
    else case (hostSel)
      2'd0: mRd = mLen;
      2'd1: mRd = mCnt;
      2'd2: mRd = mNbc;
      default: mRd = mNst;
    endcase
    mLen = nLen; mCnt = nCnt;
  end

  // per-cycle comparison
  always @(negedge clk) if (modelOn) begin
    longint idx;
    idx = (mCnt - mLen + 65536) % 65536;
    check("R7 index", descIndex, idx);
    check("R8 address", descAddr, (longint'(ringBase) + idx * 16) % 64'h1_0000_0000);
    check("R1 read data", hostRdata, mRd);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic doWrite(logic [1:0] s, logic [31:0] d);
    hostSel = s; hostWdata = d; hostWr = 1'b1; tick(); hostWr = 1'b0;
  endtask

  task automatic doRead(logic [1:0] s, string req, longint exp);
    hostSel = s; hostRd = 1'b1; tick(); hostRd = 1'b0;
    check(req, hostRdata, exp);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin advance = 1'b1; tick(); end
    advance = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check("R10 reset read zero", hostRdata, 0);
    rstN = 1'b1;
    initLen = 16'hFFFC; initLoad = 1'b1; tick(); initLoad = 1'b0;
    modelOn = 1;
    check("R4 init index", descIndex, 0);
    check("R8 base address", descAddr, 32'h1000_0000);
    stopCtl = 1'b0;
    step(3);
    check("R5 stepped index", descIndex, 3);
    step(1);
    check("R5 reached zero slot", descIndex, 4);
    step(1);
    check("R6 wrap to first", descIndex, 0);
    // gated access
    doWrite(2'd1, 32'h0000_1234);
    doRead(2'd1, "R2 gated read", 0);
    suspendCtl = 1'b1;
    doRead(2'd1, "R2 gated write dropped", 16'hFFFC);
    suspendCtl = 1'b0; stopCtl = 1'b1;
    doWrite(2'd1, 32'hABCD_FFFE);
    doRead(2'd1, "R1 R3 counter write", 16'hFFFE);
    doWrite(2'd2, 32'hFFFF_FFFF);
    doRead(2'd2, "R11 byte count", 12'hFFF);
    doWrite(2'd3, 32'h1234_5678);
    doRead(2'd3, "R11 status", 16'h5678);
    doWrite(2'd0, 32'h0000_FFF0);
    doRead(2'd0, "R1 length", 16'hFFF0);
    // write beats advance
    hostSel = 2'd1; hostWdata = 32'h0000_FFF8; hostWr = 1'b1; advance = 1'b1; tick();
    hostWr = 1'b0; advance = 1'b0;
    check("R9 write wins", descIndex, 8);
    // init beats both
    initLen = 16'hFFFD; initLoad = 1'b1; hostWr = 1'b1; hostWdata = 32'h5; advance = 1'b1; tick();
    initLoad = 1'b0; hostWr = 1'b0; advance = 1'b0;
    check("R4 init priority", descIndex, 0);
    doRead(2'd0, "R4 length loaded", 16'hFFFD);
    step(2);
    // reset keeps state
    rstN = 1'b0; repeat (2) tick();
    check("R10 reset clears read", hostRdata, 0);
    rstN = 1'b1;
    check("R10 index kept", descIndex, 2);
    doRead(2'd3, "R10 status kept", 16'h5678);
    ringBase = 32'hFFFF_FFF0; tick();
    check("R8 address wraps", descAddr, 32'h0000_0010);
    stopCtl = 1'b0;
    doRead(2'd0, "R2 no access read", 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule